// File: doc/BRIEF.md
# Address Window Switch Controller

This block steers a host-visible address window onto one of several internal cores. The window is selected by a single base register on a configuration port. To select core `k`, the block writes `ENUM_BASE + k * REGION_SIZE` to that register. It then reads the register back and confirms that the readback decodes to `k`. If the readback names a different core, the block waits a fixed time and writes again. It gives up after a bounded number of attempts, or as soon as the configuration port signals an error.

A requester issues one of three commands: a plain switch, a read, or a write. A read or write that targets the core already mapped goes straight to the window memory port. A read or write that targets any other core runs a switch first. When that switch fails, the access is not performed. A failed read returns all-ones at the requested width, and a failed write is dropped. The block records which core is mapped and changes that record only when a switch succeeds. A busy flag covers each command from acceptance to its result, and requests that arrive while the block is busy are ignored.

Top module: `win_switch_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o`, `mapped_vld_o`, `cfg_req_o` and `mem_req_o` are all low, so no core is mapped.
- R2: Every configuration write carries `ENUM_BASE + core * REGION_SIZE`, which is `0x1800_0000 + core * 0x1000` with the defaults.
- R3: A switch succeeds only when `(readback - ENUM_BASE) / REGION_SIZE` equals the requested core; readback bits below the region size are ignored.
- R4: After a mismatching readback, the next window write starts no earlier than `CLK_MHZ * WAIT_US` cycles later (2500 cycles by default) and at most 10 cycles beyond that.
- R5: Attempts are counted from zero. A mismatch when the count already exceeds `MAX_RETRY` ends in error, so a switch makes at most `MAX_RETRY + 2` window writes (4 by default). A mismatch before that point causes a retry.
- R6: An error reported by the configuration port, on either the write or the readback, ends the switch in error at once, with no retry.
- R7: A failed 16-bit read returns `0x0000FFFF` and a failed 32-bit read returns `0xFFFFFFFF`, both with `err_o`. A write whose switch fails makes no memory access.
- R8: The mapped-core record (`mapped_vld_o`, `mapped_o`) changes only after a successful readback and keeps its value when a switch fails.
- R9: A read (op 1) or write (op 2) to the currently mapped core makes no configuration access. One to another core switches first and then makes the memory access at the request's offset.
- R10: `busy_o` rises the cycle after a request is accepted and stays high through the `done_o`/`err_o` cycle. A request raised while busy is ignored.
- R11: A 32-bit read (`wide_i` = 1) returns the full memory word. A 16-bit read returns its low 16 bits, zero-extended.
- R12: A switch command (op 0, or the reserved op 3) always runs the write/readback sequence, even when the core is already mapped, and completes with `done_o` and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Command strobe, sampled when idle |
| op_i | input | 2 | 0 switch, 1 read, 2 write, 3 treated as switch |
| core_i | input | CORE_W | Target core index |
| wide_i | input | 1 | 1: 32-bit access, 0: 16-bit access |
| addr_i | input | OFF_W | Offset inside the core region |
| wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle success pulse |
| err_o | output | 1 | One-cycle failure pulse |
| rdata_o | output | 32 | Read result, valid with done_o/err_o |
| mapped_vld_o | output | 1 | A core is mapped |
| mapped_o | output | CORE_W | Currently mapped core |
| cfg_req_o | output | 1 | Window register access request |
| cfg_we_o | output | 1 | 1: write, 0: readback |
| cfg_wdata_o | output | 32 | Window base value |
| cfg_ack_i | input | 1 | Configuration access complete |
| cfg_err_i | input | 1 | Configuration access failed, valid with ack |
| cfg_rdata_i | input | 32 | Window register readback |
| mem_req_o | output | 1 | Window memory access request |
| mem_we_o | output | 1 | Memory write |
| mem_wide_o | output | 1 | Memory access width |
| mem_addr_o | output | OFF_W | Memory offset |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
The switch is exercised with four kinds of register behaviour: a register that takes the first write, one that ignores three writes, one that ignores four, and one that returns readback with low offset bits set. Together these separate success on the first attempt, success on the last attempt allowed, exhaustion of the retry limit, and a decode that ignores the low bits. Injected write errors and readback errors confirm that errors abort at once. The errors are applied to both reads and writes, at both widths, so the all-ones values and the dropped writes are visible at the memory port. Accesses alternate between the mapped core and other cores, which separates the direct path from the path that switches first. A stale mapping after a failed switch shows that the record changes only on success.

// File: rtl/win_sw_pkg.sv
package win_sw_pkg;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    OP_SWITCH = 2'd0,
    OP_READ   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_RSVD   = 2'd3
  } win_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CFG_WR,
    ST_CFG_RD,
    ST_WAIT,
    ST_MEM,
    ST_OK,
    ST_FAIL
  } win_st_e;
endpackage

// File: rtl/win_sw_addr.sv
module win_sw_addr #(
  parameter int          CORE_W    = 4,
  parameter int          SHIFT     = 12,
  parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
  input  logic [CORE_W-1:0] core_i,
  input  logic [31:0]       rb_i,
  output logic [31:0]       win_o,
  output logic              match_o
);
  logic [31:0] core_ext;
  logic [31:0] diff;

  assign core_ext = 32'(core_i);
  assign win_o    = ENUM_BASE + (core_ext << SHIFT);
  assign diff     = rb_i - ENUM_BASE;
  // integer divide by the power-of-two region size drops the low bits
  assign match_o  = (diff >> SHIFT) == core_ext;

  always_comb begin
    if (rb_i == win_o) AST_ROUNDTRIP: assert (match_o); // R3
  end
endmodule

// File: rtl/win_sw_delay.sv
module win_sw_delay #(
  parameter int CYCLES = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start_i) begin
      cnt_q <= CNT_W'(CYCLES - 1);
      act_q <= 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done_o = act_q && (cnt_q == '0);

  AST_WAIT_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o); // R4
endmodule

// File: rtl/win_switch_ctrl.sv
module win_switch_ctrl
  import win_sw_pkg::*;
#(
  parameter int          N_CORES     = 16,
  parameter int          REGION_SIZE = 4096,
  parameter logic [31:0] ENUM_BASE   = 32'h1800_0000,
  parameter int          MAX_RETRY   = 2,
  parameter int          CLK_MHZ     = 250,
  parameter int          WAIT_US     = 10,
  localparam int         CORE_W      = $clog2(N_CORES),
  localparam int         OFF_W       = $clog2(REGION_SIZE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [1:0]        op_i,
  input  logic [CORE_W-1:0] core_i,
  input  logic              wide_i,
  input  logic [OFF_W-1:0]  addr_i,
  input  logic [31:0]       wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [31:0]       rdata_o,
  output logic              mapped_vld_o,
  output logic [CORE_W-1:0] mapped_o,
  output logic              cfg_req_o,
  output logic              cfg_we_o,
  output logic [31:0]       cfg_wdata_o,
  input  logic              cfg_ack_i,
  input  logic              cfg_err_i,
  input  logic [31:0]       cfg_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_wide_o,
  output logic [OFF_W-1:0]  mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int WAIT_CYC = CLK_MHZ * WAIT_US;
  localparam int ATT_W    = $clog2(MAX_RETRY + 2) + 1;

  win_st_e             st_q, st_d;
  win_op_e             op_q;
  logic [CORE_W-1:0]   core_q, map_q;
  logic                map_vld_q, wide_q;
  logic [OFF_W-1:0]    addr_q;
  logic [31:0]         wdata_q, rdata_q;
  logic [ATT_W-1:0]    att_q;
  logic                rb_match, wait_start, wait_done;
  logic                go_fail, map_upd, att_inc;
  logic                in_acc, q_acc, hit;
  logic [31:0]         fail_word;

  win_sw_addr #(.CORE_W(CORE_W), .SHIFT(OFF_W), .ENUM_BASE(ENUM_BASE)) u_addr (
    .core_i (core_q),
    .rb_i   (cfg_rdata_i),
    .win_o  (cfg_wdata_o),
    .match_o(rb_match)
  );

  win_sw_delay #(.CYCLES(WAIT_CYC)) u_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(wait_start),
    .done_o (wait_done)
  );

  assign in_acc    = (op_i == OP_READ) || (op_i == OP_WRITE);
  assign q_acc     = (op_q == OP_READ) || (op_q == OP_WRITE);
  assign hit       = map_vld_q && (core_i == map_q);
  assign fail_word = wide_q ? 32'hFFFF_FFFF : 32'h0000_FFFF;

  always_comb begin
    st_d       = st_q;
    go_fail    = 1'b0;
    map_upd    = 1'b0;
    att_inc    = 1'b0;
    wait_start = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (req_i) st_d = (in_acc && hit) ? ST_MEM : ST_CFG_WR;
      ST_CFG_WR: if (cfg_ack_i) begin
        if (cfg_err_i) go_fail = 1'b1;
        else           st_d    = ST_CFG_RD;
      end
      ST_CFG_RD: if (cfg_ack_i) begin
        if (cfg_err_i) go_fail = 1'b1;
        else if (rb_match) begin
          map_upd = 1'b1;
          st_d    = q_acc ? ST_MEM : ST_OK;
        end else if (att_q > ATT_W'(MAX_RETRY)) go_fail = 1'b1;
        else begin
          att_inc    = 1'b1;
          wait_start = 1'b1;
          st_d       = ST_WAIT;
        end
      end
      ST_WAIT:   if (wait_done) st_d = ST_CFG_WR;
      ST_MEM:    if (mem_ack_i) st_d = ST_OK;
      default:   st_d = ST_IDLE;
    endcase
    if (go_fail) st_d = ST_FAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= OP_SWITCH;
      core_q    <= '0;
      map_q     <= '0;
      map_vld_q <= 1'b0;
      wide_q    <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rdata_q   <= '0;
      att_q     <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) begin
        op_q    <= win_op_e'(op_i);
        core_q  <= core_i;
        wide_q  <= wide_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        att_q   <= '0;
      end
      if (att_inc) att_q <= att_q + 1'b1;
      if (map_upd) begin
        map_q     <= core_q;
        map_vld_q <= 1'b1;
      end
      if (go_fail) rdata_q <= fail_word;
      else if (st_q == ST_MEM && mem_ack_i)
        rdata_q <= wide_q ? mem_rdata_i : {16'h0000, mem_rdata_i[15:0]};
    end
  end

  assign busy_o       = st_q != ST_IDLE;
  assign done_o       = st_q == ST_OK;
  assign err_o        = st_q == ST_FAIL;
  assign rdata_o      = rdata_q;
  assign mapped_vld_o = map_vld_q;
  assign mapped_o     = map_q;
  assign cfg_req_o    = (st_q == ST_CFG_WR) || (st_q == ST_CFG_RD);
  assign cfg_we_o     = st_q == ST_CFG_WR;
  assign mem_req_o    = st_q == ST_MEM;
  assign mem_we_o     = op_q == OP_WRITE;
  assign mem_wide_o   = wide_q;
  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = wdata_q;

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o && !cfg_ack_i |=> cfg_req_o && $stable(cfg_we_o)); // R2
  AST_RETRY_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    att_q <= ATT_W'(MAX_RETRY + 1)); // R5
  AST_FAIL_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && op_q == OP_READ && wide_q |-> rdata_o == 32'hFFFF_FFFF); // R7
  AST_MAP_ON_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mapped_vld_o, mapped_o}) |->
      $past(cfg_req_o && !cfg_we_o && cfg_ack_i && !cfg_err_i)); // R8
  AST_DIRECT_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && req_i && in_acc && hit |=> mem_req_o); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && !err_o |=> busy_o); // R10
  AST_ONE_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R6
endmodule

// File: tb/win_switch_ctrl_test.sv
module win_switch_ctrl_test;
  localparam logic [31:0] BASE = 32'h1800_0000;
  localparam int WAIT_CYC = 2500;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  core;
    logic        wide;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [2:0]  stuck;
    logic [1:0]  emode;   // 1 err on write, 2 err on readback, 3 low bits set in readback
    logic        exp_err;
    logic [2:0]  exp_wr;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 4'd3,  1'b1, 12'h010, 32'h0,         3'd0, 2'd0, 1'b0, 3'd1},
    '{2'd1, 4'd3,  1'b0, 12'h0A4, 32'h0,         3'd0, 2'd0, 1'b0, 3'd0},
    '{2'd2, 4'd5,  1'b1, 12'h020, 32'hDEAD_BEEF, 3'd0, 2'd0, 1'b0, 3'd1},
    '{2'd0, 4'd5,  1'b1, 12'h000, 32'h0,         3'd0, 2'd0, 1'b0, 3'd1},
    '{2'd1, 4'd7,  1'b1, 12'h100, 32'h0,         3'd3, 2'd0, 1'b0, 3'd4},
    '{2'd1, 4'd9,  1'b0, 12'h004, 32'h0,         3'd4, 2'd0, 1'b1, 3'd4},
    '{2'd1, 4'd9,  1'b1, 12'h008, 32'h0,         3'd4, 2'd0, 1'b1, 3'd4},
    '{2'd2, 4'd2,  1'b1, 12'h030, 32'h1234_5678, 3'd0, 2'd1, 1'b1, 3'd1},
    '{2'd1, 4'd2,  1'b1, 12'h040, 32'h0,         3'd0, 2'd2, 1'b1, 3'd1},
    '{2'd3, 4'd4,  1'b1, 12'h000, 32'h0,         3'd0, 2'd3, 1'b0, 3'd1},
    '{2'd1, 4'd15, 1'b1, 12'hFFF, 32'h0,         3'd0, 2'd0, 1'b0, 3'd1},
    '{2'd2, 4'd4,  1'b0, 12'h044, 32'h0000_CAFE, 3'd0, 2'd0, 1'b0, 3'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wide = 1'b0;
  logic [1:0] op = '0;
  logic [3:0] core = '0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic busy, done, err, mvld, creq, cwe, mreq, mwe, mwide;
  logic [31:0] rdata, cwdata, mwdata;
  logic [3:0] mcore;
  logic [11:0] maddr;
  logic cack = 1'b0, cerr = 1'b0, mack = 1'b0;
  logic [31:0] crdata = '0, mrdata = '0;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] win_reg = '0, last_cfg = '0, last_mem_win = '0, last_mem_data = '0;
  int op_seq = 0, seen_seq = 0, cfg_wr_cnt = 0, ignored = 0, mem_wr_cnt = 0;
  int prev_cyc = 0, last_gap = 0;
  bit have_prev = 1'b0;
  int stuck_cfg = 0, emode_cfg = 0;

  always #2 clk = ~clk;

  win_switch_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .op_i(op), .core_i(core), .wide_i(wide),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .mapped_vld_o(mvld), .mapped_o(mcore), .cfg_req_o(creq),
    .cfg_we_o(cwe), .cfg_wdata_o(cwdata), .cfg_ack_i(cack), .cfg_err_i(cerr),
    .cfg_rdata_i(crdata), .mem_req_o(mreq), .mem_we_o(mwe), .mem_wide_o(mwide),
    .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_ack_i(mack), .mem_rdata_i(mrdata)
  );

  // window register model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (seen_seq != op_seq) begin
      seen_seq   <= op_seq;
      cfg_wr_cnt <= 0;
      ignored    <= 0;
      have_prev  <= 1'b0;
    end
    if (creq && !cack) begin
      cack <= 1'b1;
      cerr <= 1'b0;
      if (cwe) begin
        cfg_wr_cnt <= cfg_wr_cnt + 1;
        last_cfg   <= cwdata;
        if (have_prev) last_gap <= cyc - prev_cyc;
        prev_cyc  <= cyc;
        have_prev <= 1'b1;
        if (emode_cfg == 1) cerr <= 1'b1;
        else if (ignored < stuck_cfg) ignored <= ignored + 1;
        else win_reg <= cwdata;
      end else begin
        if (emode_cfg == 2) cerr <= 1'b1;
        crdata <= win_reg + ((emode_cfg == 3) ? 32'h123 : 32'h0);
      end
    end else begin
      cack <= 1'b0;
      cerr <= 1'b0;
    end
  end

  // window memory model: read data identifies the mapped window and offset
  always @(posedge clk) begin
    if (mreq && !mack) begin
      mack <= 1'b1;
      if (mwe) begin
        mem_wr_cnt    <= mem_wr_cnt + 1;
        last_mem_win  <= win_reg;
        last_mem_data <= mwdata;
      end else mrdata <= win_reg ^ {20'h0, maddr};
    end else mack <= 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wait_result(output logic r_err, output logic [31:0] r_data);
    int n = 0;
    while (!(done || err) && n < 20000) begin
      @(negedge clk);
      n++;
    end
    r_err  = err;
    r_data = rdata;
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    op_seq++;
    stuck_cfg = int'(v.stuck);
    emode_cfg = int'(v.emode);
    op = v.op; core = v.core; wide = v.wide; addr = v.addr; wdata = v.wdata;
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R10 busy after accept", 32'(busy), 32'd1);
  endtask

  initial begin
    while (cyc < 150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic r_err;
    logic [31:0] r_data, exp_data, exp_win;
    logic exp_vld = 1'b0;
    logic [3:0] exp_map = '0;
    int mw_before;
    string tag;

    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {26'h0, busy, done, err, mvld, creq, mreq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {29'h0, busy, creq, mreq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      mw_before = mem_wr_cnt;
      exp_win   = BASE + (32'(VECS[i].core) << 12);
      launch(VECS[i]);
      wait_result(r_err, r_data);
      @(negedge clk);
      tag = (VECS[i].emode == 2'd1 || VECS[i].emode == 2'd2) ? "R6 error flag"
          : (VECS[i].emode == 2'd3) ? "R3 low bits ignored" : "R5 error flag";
      chk(tag, 32'(r_err), 32'(VECS[i].exp_err));
      tag = (VECS[i].exp_wr == 3'd0) ? "R9 no cfg access on hit"
          : (VECS[i].stuck != 3'd0) ? "R5 write attempts"
          : (VECS[i].op == 2'd0 || VECS[i].op == 2'd3) ? "R12 switch always runs" : "R3 write count";
      chk(tag, 32'(cfg_wr_cnt), 32'(VECS[i].exp_wr));
      if (VECS[i].exp_wr != 3'd0) chk("R2 window value", last_cfg, exp_win);
      if (!VECS[i].exp_err) begin
        exp_vld = 1'b1;
        exp_map = VECS[i].core;
      end
      chk("R8 mapped record", {27'h0, mvld, mcore}, {27'h0, exp_vld, exp_map});
      if (VECS[i].op == 2'd1) begin
        if (VECS[i].exp_err) exp_data = VECS[i].wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
        else begin
          exp_data = exp_win ^ {20'h0, VECS[i].addr};
          if (!VECS[i].wide) exp_data = {16'h0, exp_data[15:0]};
        end
        chk(VECS[i].exp_err ? "R7 all-ones read" : "R11 read data", r_data, exp_data);
      end
      if (VECS[i].op == 2'd2) begin
        if (VECS[i].exp_err) chk("R7 write dropped", 32'(mem_wr_cnt), 32'(mw_before));
        else begin
          chk("R9 write performed", 32'(mem_wr_cnt), 32'(mw_before + 1));
          chk("R9 write window", last_mem_win, exp_win);
          chk("R9 write data", last_mem_data, VECS[i].wdata);
        end
      end
      if (VECS[i].op == 2'd0 || VECS[i].op == 2'd3)
        chk("R12 no memory write", 32'(mem_wr_cnt), 32'(mw_before));
      if (VECS[i].stuck == 3'd3)
        chk("R4 retry wait", 32'((last_gap >= WAIT_CYC) && (last_gap <= WAIT_CYC + 10)), 32'd1);
      chk("R10 idle after result", 32'(busy), 32'd0);
    end

    // requests raised while busy are ignored
    mw_before = mem_wr_cnt;
    launch('{2'd1, 4'd6, 1'b1, 12'h0, 32'h0, 3'd1, 2'd0, 1'b0, 3'd2});
    repeat (20) @(negedge clk);
    op = 2'd2; core = 4'd1; wdata = 32'h5555_AAAA; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk("R10 busy held", 32'(busy), 32'd1);
    wait_result(r_err, r_data);
    chk("R10 first request result", {31'h0, r_err}, 32'd0);
    chk("R5 one retry", 32'(cfg_wr_cnt), 32'd2);
    chk("R4 wait length", 32'((last_gap >= WAIT_CYC) && (last_gap <= WAIT_CYC + 10)), 32'd1);
    repeat (5) @(negedge clk);
    chk("R10 ignored write", 32'(mem_wr_cnt), 32'(mw_before));
    chk("R10 mapped unaffected", {27'h0, mvld, mcore}, {27'h0, 1'b1, 4'd6});
    chk("R10 still idle", 32'(busy), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule